// File: doc/BRIEF.md
# Tag Check Fault Response Selector

This block sits behind a memory tag checker and decides what happens once a tag mismatch has been detected. Each cycle the checker may raise a fail strobe together with the faulting address, the access direction and two facts about the translation regime: whether it is the unprivileged (EL0) regime, and whether it splits the address space into two ranges. A 64-bit system control value carries two 2-bit response-mode fields, one for the unprivileged regime and one for privileged regimes. The block selects the field that applies and then reports the fault in one of three ways. It can send nothing. It can raise a synchronous abort request. It can set a sticky asynchronous status bit.

The synchronous abort request is a registered one-cycle pulse. It carries the fault address and the write flag. The asynchronous status is a 2-bit sticky register that software reads directly. Software clears it with a clear strobe and a per-bit mask. Which status bit a fault sets depends on address bit 55 when the regime has two address ranges. In all other cases it is bit 0.

Top module: `tag_fault_resp`

## Requirements
- R1: After reset `abort_o` is 0 and `async_status_o` is 2'b00.
- R2: The mode field is `sctl_i[39:38]` when `el0_regime_i` is 1 and `sctl_i[41:40]` otherwise; the field not selected has no effect.
- R3: Mode 0: a fail produces no abort and leaves `async_status_o` unchanged.
- R4: Mode 1: a fail in cycle k makes `abort_o` 1 in cycle k+1, with `abort_addr_o` equal to the fault address and `abort_write_o` equal to the write flag of cycle k.
- R5: Mode 2: a fail sets one asynchronous status bit from cycle k+1 and produces no abort.
- R6: Mode 3: a failing write (`is_write_i`=1) behaves as mode 2, and a failing read behaves as mode 1.
- R7: The status bit set is index `fault_addr_i[55]` when `two_range_i` is 1 and index 0 otherwise; the bit is ORed into the register, so other bits are kept.
- R8: Status bits stay set until a cycle with `clr_i`=1, which clears exactly the bits that are 1 in `clr_mask_i`.
- R9: When a bit is set by a fault and cleared in the same cycle, the bit ends up set.
- R10: `abort_o` is high only in the cycle after a fail strobe. Without a new fail it is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fail_i | input | 1 | Tag check failure strobe |
| fault_addr_i | input | 64 | Faulting virtual address |
| is_write_i | input | 1 | 1 when the failing access is a store |
| el0_regime_i | input | 1 | 1 for the unprivileged regime |
| two_range_i | input | 1 | 1 when the regime has two address ranges |
| sctl_i | input | 64 | System control value holding both mode fields |
| clr_i | input | 1 | Software status clear strobe |
| clr_mask_i | input | 2 | Status bits cleared by `clr_i` |
| abort_o | output | 1 | Synchronous abort request pulse |
| abort_addr_o | output | 64 | Fault address reported with the abort |
| abort_write_o | output | 1 | Write flag reported with the abort |
| async_status_o | output | 2 | Sticky asynchronous fault status |

## Verification
The bench sweeps every mode in both regimes, both access directions, both range settings and both values of address bit 55. In each case the field that is not selected is loaded with the complement of the wanted mode. A selector that reads the wrong field therefore aborts when it should stay silent, or the other way round. In mode 3 a swapped write flag shows up as an abort on a store. An index taken from bit 55 in single-range regimes sets bit 1 instead of bit 0. Separate sequences check that a status bit is kept through later faults, that a masked clear removes only the chosen bit, and that a set in the same cycle as a clear wins. A clear-priority design would leave the status at zero in that last case.

// File: rtl/tfr_pkg.sv
package tfr_pkg;
    typedef enum logic [1:0] {
        TCF_IGNORE = 2'd0,
        TCF_SYNC   = 2'd1,
        TCF_ASYNC  = 2'd2,
        TCF_SPLIT  = 2'd3
    } tcf_mode_e;
endpackage

// File: rtl/tfr_mode_sel.sv
module tfr_mode_sel
    import tfr_pkg::*;
#(
    parameter int CTRL_W  = 64,
    parameter int USER_LO = 38,
    parameter int PRIV_LO = 40
) (
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic              user_i,
    output tcf_mode_e         mode_o
);
    logic [1:0] user_fld;
    logic [1:0] priv_fld;

    always_comb begin
        user_fld = ctrl_i[USER_LO +: 2];
        priv_fld = ctrl_i[PRIV_LO +: 2];
        mode_o   = tcf_mode_e'(user_i ? user_fld : priv_fld);
    end
endmodule

// File: rtl/tfr_dispatch.sv
module tfr_dispatch
    import tfr_pkg::*;
#(
    parameter int STAT_W = 2,
    localparam int IDX_W = (STAT_W > 1) ? $clog2(STAT_W) : 1
) (
    input  logic              fail_i,
    input  tcf_mode_e         mode_i,
    input  logic              write_i,
    input  logic              two_range_i,
    input  logic              range_bit_i,
    output logic              sync_o,
    output logic [STAT_W-1:0] async_set_o
);
    logic             async_hit;
    logic [IDX_W-1:0] idx;

    always_comb begin
        sync_o    = 1'b0;
        async_hit = 1'b0;
        unique case (mode_i)
            TCF_IGNORE: ;
            TCF_SYNC:   sync_o    = fail_i;
            TCF_ASYNC:  async_hit = fail_i;
            TCF_SPLIT: begin
                async_hit = fail_i & write_i;
                sync_o    = fail_i & ~write_i;
            end
            default: ;
        endcase
        idx = two_range_i ? IDX_W'(range_bit_i) : '0;
    end

    for (genvar g = 0; g < STAT_W; g++) begin : g_set
        assign async_set_o[g] = async_hit && (idx == IDX_W'(g));
    end
endmodule

// File: rtl/tfr_status.sv
module tfr_status #(
    parameter int STAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_i,
    input  logic              clr_i,
    input  logic [STAT_W-1:0] clr_mask_i,
    output logic [STAT_W-1:0] status_o
);
    logic [STAT_W-1:0] status_d, status_q;

    always_comb begin
        status_d = status_q;
        if (clr_i) status_d = status_d & ~clr_mask_i;
        status_d = status_d | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    assign status_o = status_q;

    // Bits only fall in the cycle after a clear
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((status_q & $past(status_q)) == $past(status_q)));

    // A set in the same cycle as a clear wins
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/tag_fault_resp.sv
module tag_fault_resp
    import tfr_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int CTRL_W    = 64,
    parameter int USER_LO   = 38,
    parameter int PRIV_LO   = 40,
    parameter int RANGE_BIT = 55,
    parameter int STAT_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fail_i,
    input  logic [ADDR_W-1:0] fault_addr_i,
    input  logic              is_write_i,
    input  logic              el0_regime_i,
    input  logic              two_range_i,
    input  logic [CTRL_W-1:0] sctl_i,
    input  logic              clr_i,
    input  logic [STAT_W-1:0] clr_mask_i,
    output logic              abort_o,
    output logic [ADDR_W-1:0] abort_addr_o,
    output logic              abort_write_o,
    output logic [STAT_W-1:0] async_status_o
);
    typedef struct packed {
        logic              abort;
        logic [ADDR_W-1:0] addr;
        logic              wr;
    } abort_st_t;

    tcf_mode_e         mode;
    logic              sync_req;
    logic [STAT_W-1:0] async_set;
    abort_st_t         st_d, st_q;

    tfr_mode_sel #(.CTRL_W(CTRL_W), .USER_LO(USER_LO), .PRIV_LO(PRIV_LO)) u_sel (
        .ctrl_i (sctl_i),
        .user_i (el0_regime_i),
        .mode_o (mode)
    );

    tfr_dispatch #(.STAT_W(STAT_W)) u_disp (
        .fail_i      (fail_i),
        .mode_i      (mode),
        .write_i     (is_write_i),
        .two_range_i (two_range_i),
        .range_bit_i (fault_addr_i[RANGE_BIT]),
        .sync_o      (sync_req),
        .async_set_o (async_set)
    );

    tfr_status #(.STAT_W(STAT_W)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (async_set),
        .clr_i      (clr_i),
        .clr_mask_i (clr_mask_i),
        .status_o   (async_status_o)
    );

    always_comb begin
        st_d       = st_q;
        st_d.abort = sync_req;
        if (sync_req) begin
            st_d.addr = fault_addr_i;
            st_d.wr   = is_write_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign abort_o       = st_q.abort;
    assign abort_addr_o  = st_q.addr;
    assign abort_write_o = st_q.wr;

    logic [1:0] fld;
    assign fld = el0_regime_i ? sctl_i[USER_LO +: 2] : sctl_i[PRIV_LO +: 2];

    assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> $past(fail_i));

    assert_abort_info_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_i && fld == 2'd1) |=> (abort_o && abort_addr_o == $past(fault_addr_i)
                                     && abort_write_o == $past(is_write_i)));

    assert_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_i && fld == 2'd0) |=> !abort_o);

    assert_async_noabort_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_i && fld == 2'd2) |=> (!abort_o && async_status_o != '0));

    assert_split_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_i && fld == 2'd3) |=> (abort_o == !$past(is_write_i)));

    assert_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_i && fld == 2'd2 && !two_range_i) |=> async_status_o[0]);
endmodule

// File: tb/test_tag_fault_resp.sv
module test_tag_fault_resp;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fail_i = 1'b0;
    logic [63:0] fault_addr_i = '0;
    logic        is_write_i = 1'b0;
    logic        el0_regime_i = 1'b0;
    logic        two_range_i = 1'b0;
    logic [63:0] sctl_i = '0;
    logic        clr_i = 1'b0;
    logic [1:0]  clr_mask_i = '0;
    logic        abort_o;
    logic [63:0] abort_addr_o;
    logic        abort_write_o;
    logic [1:0]  async_status_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    tag_fault_resp i_tag_fault_resp (
        .clk, .rst_n, .fail_i, .fault_addr_i, .is_write_i, .el0_regime_i,
        .two_range_i, .sctl_i, .clr_i, .clr_mask_i,
        .abort_o, .abort_addr_o, .abort_write_o, .async_status_o
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_ctrl(input logic el0, input logic [1:0] m);
        logic [63:0] c;
        c = 64'h5A5A_0000_C3C3_0000;
        if (el0) begin c[39:38] = m; c[41:40] = ~m; end
        else     begin c[41:40] = m; c[39:38] = ~m; end
        return c;
    endfunction

    // drive one fail at a negedge; values are sampled at the following posedge
    task automatic fire(input logic el0, input logic [1:0] m, input logic wr,
                        input logic tr, input logic [63:0] a);
        fail_i = 1'b1; el0_regime_i = el0; sctl_i = mk_ctrl(el0, m);
        is_write_i = wr; two_range_i = tr; fault_addr_i = a;
        @(negedge clk);
        fail_i = 1'b0;
    endtask

    task automatic clear(input logic [1:0] mask);
        clr_i = 1'b1; clr_mask_i = mask;
        @(negedge clk);
        clr_i = 1'b0; clr_mask_i = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 abort after reset", 64'(abort_o), 64'd0);
        chk("R1 status after reset", 64'(async_status_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int n = 0; n < 64; n++) begin
            logic [1:0]  m;
            logic        el0, wr, tr, b55, exp_sync, exp_async;
            logic [63:0] a;
            logic [1:0]  exp_st;
            m = n[1:0]; el0 = n[2]; wr = n[3]; tr = n[4]; b55 = n[5];
            a = 64'h0123_4567_89AB_CDEF ^ 64'(n * 32'h0101_0111);
            a[55] = b55;
            exp_sync  = (m == 2'd1) || (m == 2'd3 && !wr);
            exp_async = (m == 2'd2) || (m == 2'd3 && wr);
            exp_st    = exp_async ? ((tr && b55) ? 2'b10 : 2'b01) : 2'b00;
            clear(2'b11);
            fire(el0, m, wr, tr, a);
            // R2 R3 R4 R5 R6 R7 checked per mode/regime/direction/range
            chk($sformatf("R2/R4/R6 abort m=%0d el0=%0d wr=%0d", m, el0, wr),
                64'(abort_o), 64'(exp_sync));
            if (exp_sync) begin
                chk("R4 abort addr", abort_addr_o, a);
                chk("R4 abort write", 64'(abort_write_o), 64'(wr));
            end
            chk($sformatf("R3/R5/R7 status m=%0d tr=%0d b55=%0d", m, tr, b55),
                64'(async_status_o), 64'(exp_st));
            @(negedge clk);
            chk("R10 single-cycle abort", 64'(abort_o), 64'd0);
            chk("R8 status held", 64'(async_status_o), 64'(exp_st));
        end

        // R7 OR accumulation and R8 masked clear
        clear(2'b11);
        fire(1'b0, 2'd2, 1'b0, 1'b1, 64'h0080_0000_0000_0000);
        fire(1'b1, 2'd2, 1'b1, 1'b0, 64'h0080_0000_0000_0000);
        chk("R7 OR into status", 64'(async_status_o), 64'd3);
        fire(1'b0, 2'd0, 1'b1, 1'b1, 64'h0);
        chk("R3 mode0 keeps status", 64'(async_status_o), 64'd3);
        clear(2'b01);
        chk("R8 masked clear", 64'(async_status_o), 64'd2);

        // R9 set and clear in the same cycle
        clr_i = 1'b1; clr_mask_i = 2'b11;
        fire(1'b0, 2'd2, 1'b0, 1'b0, 64'h0);
        clr_i = 1'b0; clr_mask_i = '0;
        chk("R9 set beats clear", 64'(async_status_o), 64'd1);

        // R10 back-to-back sync faults then idle
        fire(1'b1, 2'd1, 1'b1, 1'b0, 64'hDEAD);
        chk("R10 first abort", 64'(abort_o), 64'd1);
        fire(1'b1, 2'd1, 1'b0, 1'b0, 64'hBEEF);
        chk("R4 second abort addr", abort_addr_o, 64'hBEEF);
        chk("R4 second abort write", 64'(abort_write_o), 64'd0);
        @(negedge clk);
        chk("R10 abort drops", 64'(abort_o), 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule